// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Add Trap

This block is the combinational execute step for the register-register and register-immediate integer operations of a 32-bit load/store processor. A pipeline feeds it one instruction word together with the two source operand values already read from the register file. In the same cycle it returns the computed value, the index of the register to write, a write enable, and a flag that asks the pipeline to raise an arithmetic overflow exception.

The supported operations are add in signed and wrapping forms, bitwise and/or, signed and unsigned set-less-than, load-upper-immediate, and logical left shift by a constant or by a register amount. Each of these comes in a register form, an immediate form, or both. When a trapping add overflows, the write is cancelled and the flag is raised. An instruction the unit does not handle produces no write, so the pipeline can route it to another unit. A write aimed at register 0 is always dropped.

Top module: `exec_unit`

## Requirements
- R1: Field positions are: opcode bits 31:26, rs bits 25:21, rt bits 20:16, rd bits 15:11, shamt bits 10:6, funct bits 5:0, immediate bits 15:0. Add operations (opcode 000000 funct 100000 or 100001, opcode 001000, opcode 001001) return the 32-bit wrapped sum of rs_val and the second operand. For the immediate forms, the second operand is the immediate sign-extended to 32 bits.
- R2: The trapping adds (funct 100000, opcode 001000) set ovf_trap when both addends have the same sign and the sum has the opposite sign. While ovf_trap is 1, wr_en is 0.
- R3: The wrapping adds (funct 100001, opcode 001001) never set ovf_trap, for any operand values.
- R4: funct 100100 and funct 100101 return rs_val AND rt_val and rs_val OR rt_val. Opcode 001100 (and) and opcode 001101 (or) combine rs_val with the zero-extended immediate.
- R5: Signed compare (funct 101010, opcode 001010) and unsigned compare (funct 101011, opcode 001011) return 1 when rs_val is less than the second operand and 0 otherwise. The immediate forms use the sign-extended immediate, and the unsigned form compares that value as unsigned.
- R6: Opcode 001111 returns the immediate in bits 31:16 with bits 15:0 cleared.
- R7: funct 000000 shifts rt_val left by shamt. funct 000100 shifts rt_val left by rs_val bits 4:0. Both fill with zeros.
- R8: Opcode 000000 instructions name their destination in rd. Immediate instructions name it in rt.
- R9: A supported instruction with destination index 0 gives wr_en 0. Its result is still driven.
- R10: Any other opcode, or any other funct under opcode 000000, gives result 0, dest_idx 0, wr_en 0 and ovf_trap 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the register named by rs |
| rt_val | input | 32 | Value of the register named by rt |
| result | output | 32 | Computed value |
| dest_idx | output | 5 | Register index to write |
| wr_en | output | 1 | Commit result to dest_idx |
| ovf_trap | output | 1 | Signed add overflow exception request |

## Verification
Adds are tried at the four signed-overflow corners: positive plus positive and negative plus negative that cross the range limit, and neighbouring sums that stop just short of it. This shows whether the trap keys on the sign of the result or on the carry out, and whether the wrapping forms stay silent. Compares use operands whose signed and unsigned orderings disagree, plus a negative immediate, to expose sign handling. The logical immediates use a value with bit 15 set, which separates zero extension from sign extension. Shifts use amounts 0, 31 and register amounts with junk in the high bits. Random mixes over all fifteen operations, all register indices (including 0) and unsupported encodings then cover the destination selection and the write masking.

// File: rtl/exec_pkg.sv
// Shared encodings and the decoded control word of the execute unit.
// Assumes the fixed 32-bit instruction layout described in the brief.
package exec_pkg;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;
    localparam int IMM_W  = 16;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_ADDI  = 6'b001000;
    localparam logic [5:0] OPC_ADDIU = 6'b001001;
    localparam logic [5:0] OPC_SLTI  = 6'b001010;
    localparam logic [5:0] OPC_SLTIU = 6'b001011;
    localparam logic [5:0] OPC_ANDI  = 6'b001100;
    localparam logic [5:0] OPC_ORI   = 6'b001101;
    localparam logic [5:0] OPC_LUI   = 6'b001111;

    localparam logic [5:0] FN_SLL  = 6'b000000;
    localparam logic [5:0] FN_SLLV = 6'b000100;
    localparam logic [5:0] FN_ADD  = 6'b100000;
    localparam logic [5:0] FN_ADDU = 6'b100001;
    localparam logic [5:0] FN_AND  = 6'b100100;
    localparam logic [5:0] FN_OR   = 6'b100101;
    localparam logic [5:0] FN_SLT  = 6'b101010;
    localparam logic [5:0] FN_SLTU = 6'b101011;

    typedef enum logic [2:0] {
        ALU_NONE, ALU_ADD, ALU_AND, ALU_OR, ALU_SLT, ALU_SLTU, ALU_LUI, ALU_SHL
    } alu_op_e;

    typedef struct packed {
        alu_op_e            op;
        logic               legal;
        logic               trap_en;
        logic               use_imm;
        logic               imm_zext;
        logic               shift_var;
        logic [RIDX_W-1:0]  dest;
    } exec_ctrl_t;
endpackage

// File: rtl/exec_decode.sv
// Instruction decoder: maps opcode/funct to a control word and picks the
// destination field. Assumes a 32-bit instruction word; unknown encodings
// leave the control word at its all-zero (not legal) value.
module exec_decode
    import exec_pkg::*;
(
    input  logic [31:0] instr,
    output exec_ctrl_t  ctrl
);
    logic [5:0]        opcode;
    logic [5:0]        funct;
    logic [RIDX_W-1:0] f_rt;
    logic [RIDX_W-1:0] f_rd;

    assign opcode = instr[31:26];
    assign funct  = instr[5:0];
    assign f_rt   = instr[20:16];
    assign f_rd   = instr[15:11];

    // Purpose: classify the instruction and fill in the control word.
    always_comb begin
        ctrl    = '0;
        ctrl.op = ALU_NONE;
        if (opcode == OPC_RTYPE) begin
            ctrl.legal = 1'b1;
            ctrl.dest  = f_rd;
            unique case (funct)
                FN_ADD:  begin ctrl.op = ALU_ADD; ctrl.trap_en = 1'b1; end
                FN_ADDU: ctrl.op = ALU_ADD;
                FN_AND:  ctrl.op = ALU_AND;
                FN_OR:   ctrl.op = ALU_OR;
                FN_SLT:  ctrl.op = ALU_SLT;
                FN_SLTU: ctrl.op = ALU_SLTU;
                FN_SLL:  ctrl.op = ALU_SHL;
                FN_SLLV: begin ctrl.op = ALU_SHL; ctrl.shift_var = 1'b1; end
                default: begin ctrl.legal = 1'b0; ctrl.dest = '0; end
            endcase
        end else begin
            ctrl.legal   = 1'b1;
            ctrl.use_imm = 1'b1;
            ctrl.dest    = f_rt;
            unique case (opcode)
                OPC_ADDI:  begin ctrl.op = ALU_ADD; ctrl.trap_en = 1'b1; end
                OPC_ADDIU: ctrl.op = ALU_ADD;
                OPC_SLTI:  ctrl.op = ALU_SLT;
                OPC_SLTIU: ctrl.op = ALU_SLTU;
                OPC_ANDI:  begin ctrl.op = ALU_AND; ctrl.imm_zext = 1'b1; end
                OPC_ORI:   begin ctrl.op = ALU_OR;  ctrl.imm_zext = 1'b1; end
                OPC_LUI:   ctrl.op = ALU_LUI;
                default:   begin
                    ctrl.legal   = 1'b0;
                    ctrl.use_imm = 1'b0;
                    ctrl.dest    = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/exec_shift.sv
// Logarithmic left shifter with zero fill. One generated stage per bit of
// the shift amount. Assumes W is a power of two.
module exec_shift #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [SW+1];

    assign stage[0] = din;

    // Purpose: stage k shifts by 2**k when bit k of the amount is set.
    for (genvar k = 0; k < SW; k++) begin : g_stage
        assign stage[k+1] = amt[k] ? (stage[k] << (1 << k)) : stage[k];
    end

    assign dout = stage[SW];
endmodule

// File: rtl/exec_alu.sv
// Operand selection, shared adder, logic ops, compares and upper-immediate.
// Overflow is computed only for trapping adds. Assumes XLEN >= 2*IMM_W.
module exec_alu
    import exec_pkg::*;
#(
    parameter int XW = XLEN,
    localparam int SW = $clog2(XW)
) (
    input  exec_ctrl_t       ctrl,
    input  logic [XW-1:0]    rs_val,
    input  logic [XW-1:0]    rt_val,
    input  logic [IMM_W-1:0] imm,
    input  logic [SW-1:0]    shamt,
    output logic [XW-1:0]    result,
    output logic             ovf
);
    logic [XW-1:0] imm_ext;
    logic [XW-1:0] opb;
    logic [XW-1:0] sum;
    logic [XW-1:0] shl;
    logic [SW-1:0] sh_amt;

    // Purpose: extend the immediate and choose the second operand.
    always_comb begin
        imm_ext = ctrl.imm_zext ? {{(XW-IMM_W){1'b0}}, imm}
                                : {{(XW-IMM_W){imm[IMM_W-1]}}, imm};
        opb     = ctrl.use_imm ? imm_ext : rt_val;
    end

    assign sum    = rs_val + opb;
    assign sh_amt = ctrl.shift_var ? rs_val[SW-1:0] : shamt;

    exec_shift #(.W(XW)) u_shift (
        .din  (rt_val),
        .amt  (sh_amt),
        .dout (shl)
    );

    // Purpose: pick the operation result.
    always_comb begin
        unique case (ctrl.op)
            ALU_ADD:  result = sum;
            ALU_AND:  result = rs_val & opb;
            ALU_OR:   result = rs_val | opb;
            ALU_SLT:  result = {{(XW-1){1'b0}}, ($signed(rs_val) < $signed(opb))};
            ALU_SLTU: result = {{(XW-1){1'b0}}, (rs_val < opb)};
            ALU_LUI:  result = {imm, {(XW-IMM_W){1'b0}}};
            ALU_SHL:  result = shl;
            default:  result = '0;
        endcase
    end

    // Purpose: signed overflow test for trapping adds.
    assign ovf = (ctrl.op == ALU_ADD) && ctrl.trap_en &&
                 (rs_val[XW-1] == opb[XW-1]) && (sum[XW-1] != rs_val[XW-1]);

    // Purpose: guard the arithmetic outputs.
    always_comb begin
        if (!ctrl.trap_en) begin
            assert_no_overflow_R3: assert (!ovf)
                else $error("wrapping add raised overflow");
        end
        if (ctrl.op == ALU_LUI) begin
            assert_lui_low_clear_R6: assert (result[IMM_W-1:0] == '0)
                else $error("upper-immediate low half not clear");
        end
        if (ctrl.op == ALU_SLT || ctrl.op == ALU_SLTU) begin
            assert_cmp_boolean_R5: assert (result[XW-1:1] == '0)
                else $error("compare result not 0/1");
        end
    end
endmodule

// File: rtl/exec_unit.sv
// Top of the integer execute unit. Fully combinational: decodes the
// instruction, computes the value and gates the register write with
// legality, overflow and the hard-wired zero register.
module exec_unit
    import exec_pkg::*;
#(
    parameter int XW = XLEN,
    localparam int SW = $clog2(XW)
) (
    input  logic [31:0]       instr,
    input  logic [XW-1:0]     rs_val,
    input  logic [XW-1:0]     rt_val,
    output logic [XW-1:0]     result,
    output logic [RIDX_W-1:0] dest_idx,
    output logic              wr_en,
    output logic              ovf_trap
);
    exec_ctrl_t ctrl;
    logic       ovf;

    exec_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    exec_alu #(.XW(XW)) u_alu (
        .ctrl   (ctrl),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .imm    (instr[IMM_W-1:0]),
        .shamt  (instr[6+SW-1:6]),
        .result (result),
        .ovf    (ovf)
    );

    // Purpose: drive destination, write gate and trap flag.
    always_comb begin
        dest_idx = ctrl.dest;
        ovf_trap = ovf;
        wr_en    = ctrl.legal && !ovf && (ctrl.dest != '0);
    end

    // Purpose: guard the write-side outputs.
    always_comb begin
        if (ovf_trap) begin
            assert_trap_blocks_write_R2: assert (!wr_en)
                else $error("write during overflow trap");
        end
        if (wr_en) begin
            assert_zero_dest_masked_R9: assert (dest_idx != '0)
                else $error("write to register 0");
        end
        if (!ctrl.legal) begin
            assert_unsupported_quiet_R10: assert (!wr_en && !ovf_trap && result == '0)
                else $error("unsupported instruction had an effect");
        end
    end
endmodule

// File: tb/sim_exec_unit.sv
// Bench: behavioural reference model, one vector per clock, compared at
// the falling edge.
module sim_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] result;
    logic [4:0]  dest_idx;
    logic        wr_en;
    logic        ovf_trap;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    exec_unit u0 (
        .instr    (instr),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .result   (result),
        .dest_idx (dest_idx),
        .wr_en    (wr_en),
        .ovf_trap (ovf_trap)
    );

    // Reference model written from the requirements.
    task automatic ref_model(input logic [31:0] ins, input logic [31:0] a,
                             input logic [31:0] b, output logic [31:0] r,
                             output logic [4:0] d, output logic w,
                             output logic o, output string tag);
        logic [5:0]  opc = ins[31:26];
        logic [5:0]  fn  = ins[5:0];
        logic [31:0] sx  = {{16{ins[15]}}, ins[15:0]};
        logic [31:0] zx  = {16'h0, ins[15:0]};
        longint      s;
        logic        ok = 1'b1;
        r = 0; o = 0; tag = "R10";
        if (opc == 6'b000000) begin
            d = ins[15:11];
            case (fn)
                6'b100000: begin s = longint'($signed(a)) + longint'($signed(b));
                                 r = a + b; o = (s > 64'sd2147483647) || (s < -64'sd2147483648);
                                 tag = "R2"; end
                6'b100001: begin r = a + b; tag = "R3"; end
                6'b100100: begin r = a & b; tag = "R4"; end
                6'b100101: begin r = a | b; tag = "R4"; end
                6'b101010: begin r = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R5"; end
                6'b101011: begin r = (a < b) ? 1 : 0; tag = "R5"; end
                6'b000000: begin r = b << ins[10:6]; tag = "R7"; end
                6'b000100: begin r = b << a[4:0]; tag = "R7"; end
                default:   ok = 1'b0;
            endcase
        end else begin
            d = ins[20:16];
            case (opc)
                6'b001000: begin s = longint'($signed(a)) + longint'($signed(sx));
                                 r = a + sx; o = (s > 64'sd2147483647) || (s < -64'sd2147483648);
                                 tag = "R2"; end
                6'b001001: begin r = a + sx; tag = "R1"; end
                6'b001010: begin r = ($signed(a) < $signed(sx)) ? 1 : 0; tag = "R5"; end
                6'b001011: begin r = (a < sx) ? 1 : 0; tag = "R5"; end
                6'b001100: begin r = a & zx; tag = "R4"; end
                6'b001101: begin r = a | zx; tag = "R4"; end
                6'b001111: begin r = {ins[15:0], 16'h0}; tag = "R6"; end
                default:   ok = 1'b0;
            endcase
        end
        if (!ok) begin d = 0; w = 0; end
        else begin
            w = !o && (d != 0);
            if (d == 0) tag = {tag, "/R9"};
            else tag = {tag, "/R8"};
        end
    endtask

    task automatic apply(input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b);
        logic [31:0] er; logic [4:0] ed; logic ew, eo; string tag;
        @(posedge clk);
        instr = ins; rs_val = a; rt_val = b;
        ref_model(ins, a, b, er, ed, ew, eo, tag);
        @(negedge clk);
        n_vec++;
        if (result !== er || dest_idx !== ed || wr_en !== ew || ovf_trap !== eo) begin
            n_bad++;
            $display("FAIL %s instr=%h: got r=%h d=%0d w=%b o=%b exp r=%h d=%0d w=%b o=%b",
                     tag, ins, result, dest_idx, wr_en, ovf_trap, er, ed, ew, eo);
        end
    endtask

    function automatic logic [31:0] rtype(input logic [5:0] fn, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [4:0] rd,
                                          input logic [4:0] sh);
        return {6'b000000, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] opc, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] im);
        return {opc, rs, rt, im};
    endfunction

    localparam logic [5:0] FNS [8] = '{6'h20, 6'h21, 6'h24, 6'h25, 6'h2a, 6'h2b, 6'h00, 6'h04};
    localparam logic [5:0] OPS [7] = '{6'h08, 6'h09, 6'h0a, 6'h0b, 6'h0c, 6'h0d, 6'h0f};
    localparam logic [31:0] EDGE [6] = '{32'h7fffffff, 32'h80000000, 32'h00000001,
                                         32'hffffffff, 32'h00000000, 32'h7ffffffe};

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Quiet state: all-zero word is shift into register 0 (R9)
        apply(32'h0, 32'h0, 32'h0);
        // R1 add forms, negative immediate
        apply(rtype(6'h21, 1, 2, 3, 0), 32'h0000_0005, 32'hffff_fffd);
        apply(itype(6'h09, 1, 4, 16'hfff0), 32'h0000_0020, 32'h0);
        // R2 overflow corners and near misses
        apply(rtype(6'h20, 1, 2, 3, 0), 32'h7fffffff, 32'h00000001);
        apply(rtype(6'h20, 1, 2, 3, 0), 32'h80000000, 32'hffffffff);
        apply(rtype(6'h20, 1, 2, 3, 0), 32'h7ffffffe, 32'h00000001);
        apply(itype(6'h08, 1, 5, 16'h8000), 32'h80000000, 32'h0);
        apply(itype(6'h08, 1, 5, 16'h7fff), 32'h7fff0000, 32'h0);
        // R3 wrapping adds at the same corners
        apply(rtype(6'h21, 1, 2, 3, 0), 32'h7fffffff, 32'h00000001);
        apply(itype(6'h09, 1, 5, 16'h8000), 32'h80000000, 32'h0);
        // R4 zero extension of logical immediates
        apply(itype(6'h0c, 1, 6, 16'hf00f), 32'hffffffff, 32'h0);
        apply(itype(6'h0d, 1, 6, 16'h8001), 32'h12340000, 32'h0);
        apply(rtype(6'h24, 1, 2, 7, 0), 32'hf0f0f0f0, 32'h0ff00ff0);
        // R5 signed vs unsigned ordering
        apply(rtype(6'h2a, 1, 2, 8, 0), 32'hffffffff, 32'h00000001);
        apply(rtype(6'h2b, 1, 2, 8, 0), 32'hffffffff, 32'h00000001);
        apply(itype(6'h0a, 1, 8, 16'hffff), 32'hfffffffe, 32'h0);
        apply(itype(6'h0b, 1, 8, 16'hffff), 32'hfffffffe, 32'h0);
        // R6 upper immediate, rs field ignored
        apply(itype(6'h0f, 31, 9, 16'hbeef), 32'hffffffff, 32'h0);
        // R7 shifts: 0, 31, variable with junk high bits
        apply(rtype(6'h00, 0, 2, 10, 0), 32'h0, 32'h8000_0001);
        apply(rtype(6'h00, 0, 2, 10, 31), 32'h0, 32'h0000_0003);
        apply(rtype(6'h04, 1, 2, 10, 5'h1f), 32'hffff_ffe4, 32'h0000_00ff);
        // R9 destination zero, R10 unsupported encodings
        apply(itype(6'h09, 1, 0, 16'h0001), 32'h1, 32'h0);
        apply(rtype(6'h22, 1, 2, 3, 0), 32'h5, 32'h1);
        apply(itype(6'h23, 1, 2, 16'h0004), 32'h5, 32'h1);
        // Random mixes
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a = $urandom();
            logic [31:0] b = $urandom();
            logic [31:0] ins;
            int k = $urandom_range(0, 15);
            if ($urandom_range(0, 3) == 0) a = EDGE[$urandom_range(0, 5)];
            if ($urandom_range(0, 3) == 0) b = EDGE[$urandom_range(0, 5)];
            if (k < 8) ins = rtype(FNS[k], 5'($urandom()), 5'($urandom()),
                                   5'($urandom()), 5'($urandom()));
            else if (k < 15) ins = itype(OPS[k-8], 5'($urandom()), 5'($urandom()),
                                         16'($urandom()));
            else ins = $urandom();
            apply(ins, a, b);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout exp finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule